// File: doc/BRIEF.md
# Parallel Input Port Latch

This block is the read side of an 8-bit parallel input port. The port sits behind a peripheral adapter that receives bytes from a disk shift register. The input pins always carry the byte the shift register is assembling. A byte-ready strobe marks the moment a complete byte is present. On the rising edge of that strobe, an armed latch captures the pins and then freezes. The latch stays frozen until software reads the port at offset 1. That read returns the frozen byte, re-arms the latch, clears the byte-ready flag and, in handshake mode, pulses the handshake output low.

A second address, offset F, gives software a side-effect-free view of the live pins. This read leaves the latch, the flag and the handshake line untouched. When the latch-enable configuration input is low, offset 1 also returns the live pins. Other register offsets read as zero in this block, because they belong to logic elsewhere.

Top module: `inport_latch`

## Requirements
- R1: After reset the latch is armed and holds 8'h00, the byte-ready flag is 0 and the handshake output is 1. An offset-1 read before any strobe returns 8'h00.
- R2: With latch enable high, an offset-1 read (reg_sel = 4'h1) returns the captured byte, not the present value of the pins.
- R3: An offset-F read (reg_sel = 4'hF) returns the present pin value in the same cycle. It leaves the handshake output high and the byte-ready flag unchanged.
- R4: An offset-1 read re-arms the latch. An offset-F read leaves the latch frozen, so a strobe after an offset-F read is not captured.
- R5: If several strobes arrive with no offset-1 read between them, the next offset-1 read returns the byte of the first strobe.
- R6: If an offset-1 read follows each strobe, a further offset-1 read returns the byte of the most recent strobe.
- R7: A rising strobe edge sets the byte-ready flag, visible one clock later. An offset-1 read clears the flag one clock later and an offset-F read does not. If an edge and an offset-1 read fall in the same cycle, the flag ends up set.
- R8: With hs_mode high, the handshake output is 0 for exactly the one clock cycle that follows an offset-1 read and is 1 otherwise. With hs_mode low it stays 1.
- R9: With latch enable low, an offset-1 read returns the present pin value.
- R10: If a rising strobe edge and an offset-1 read occur in the same cycle, the read returns the previously latched byte, that strobe is not captured, and the latch is left armed.
- R11: Only the rising edge captures. A strobe held high for several cycles captures once, and a pin change while it stays high does not reach the latch.
- R12: A read at any offset other than 1 or F returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_pins | input | 8 | Live byte from the shift register |
| byte_rdy | input | 1 | Byte-ready strobe, active on its rising edge |
| latch_en | input | 1 | Latch enable; when low, offset 1 shows live pins |
| hs_mode | input | 1 | Read-handshake mode enable |
| reg_sel | input | 4 | Register offset of the CPU access |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Read data, combinational in the read cycle |
| hs_n | output | 1 | Handshake output, active low |
| rdy_flag | output | 1 | Byte-ready interrupt flag |

## Verification
The armed/frozen state cannot be observed directly. A wrong value there shows up as a wrong byte on the first offset-1 read after the next strobe. A latch that never re-arms returns a stale byte. A latch that never freezes returns the newest byte instead of the first one. Flag and handshake faults show on the negative clock edge right after the offending cycle, which is one register stage away. Read data is combinational, so a wrong read path shows in the read cycle itself.

// File: rtl/inport_latch.sv
module inport_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] port_pins,
  input  logic       byte_rdy,
  input  logic       latch_en,
  input  logic       hs_mode,
  input  logic [3:0] reg_sel,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       hs_n,
  output logic       rdy_flag
);

  localparam logic [3:0] SEL_HELD = 4'h1;
  localparam logic [3:0] SEL_LIVE = 4'hF;

  logic       rdy_q;
  logic       armed;
  logic [7:0] held;

  wire rise    = byte_rdy & ~rdy_q;
  wire rd_held = rd_en & (reg_sel == SEL_HELD);
  wire rd_live = rd_en & (reg_sel == SEL_LIVE);

  assign rd_data = rd_held ? (latch_en ? held : port_pins) :
                   rd_live ? port_pins : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      armed    <= 1'b1;
      held     <= 8'h00;
      rdy_flag <= 1'b0;
      hs_n     <= 1'b1;
    end else begin
      rdy_q <= byte_rdy;
      if (rd_held)
        armed <= 1'b1;
      else if (rise && armed && latch_en) begin
        held  <= port_pins;
        armed <= 1'b0;
      end
      if (rise)
        rdy_flag <= 1'b1;
      else if (rd_held)
        rdy_flag <= 1'b0;
      hs_n <= ~(hs_mode & rd_held);
    end
  end

  assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_held |=> armed);

  assert_live_no_touch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && !rise) |=> ($stable(held) && armed == $past(armed)));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(held));

  assert_live_no_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_live |=> hs_n);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> rdy_flag);

  assert_flag_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_held && !rise) |=> !rdy_flag);

  assert_hs_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && rd_held) |=> !hs_n);

  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_held && rise) |=> ($stable(held) && armed));

endmodule

// File: tb/inport_latch_bench.sv
module inport_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_pins = 8'h00;
  logic       byte_rdy = 1'b0;
  logic       latch_en = 1'b1;
  logic       hs_mode = 1'b1;
  logic [3:0] reg_sel = 4'h0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       hs_n;
  logic       rdy_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  inport_latch u_inport_latch (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .byte_rdy(byte_rdy),
    .latch_en(latch_en), .hs_mode(hs_mode), .reg_sel(reg_sel), .rd_en(rd_en),
    .rd_data(rd_data), .hs_n(hs_n), .rdy_flag(rdy_flag)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] v);
    @(negedge clk);
    port_pins = v; byte_rdy = 1'b1;
    @(negedge clk);
    byte_rdy = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 flag", {7'b0, rdy_flag}, 8'h00);
    check("R1 hs_n", {7'b0, hs_n}, 8'h01);
    port_pins = 8'h5A;
    rd(4'h1, d);
    check("R1 first read", d, 8'h00);
    check("R8 hs pulse low", {7'b0, hs_n}, 8'h00);
    @(negedge clk);
    check("R8 hs back high", {7'b0, hs_n}, 8'h01);
  endtask

  task automatic t_latch_vs_live;
    logic [7:0] d;
    strobe(8'hA1);
    check("R7 flag set", {7'b0, rdy_flag}, 8'h01);
    port_pins = 8'h3C;
    rd(4'hF, d);
    check("R3 live read", d, 8'h3C);
    check("R3 no handshake", {7'b0, hs_n}, 8'h01);
    check("R7 flag kept by F", {7'b0, rdy_flag}, 8'h01);
    strobe(8'hB2);
    rd(4'h1, d);
    check("R2 R4 latched byte kept", d, 8'hA1);
    check("R7 flag cleared", {7'b0, rdy_flag}, 8'h00);
  endtask

  task automatic t_many_strobes;
    logic [7:0] d;
    strobe(8'h11);
    strobe(8'h22);
    strobe(8'h33);
    rd(4'h1, d);
    check("R5 first byte wins", d, 8'h11);
  endtask

  task automatic t_keep_current;
    logic [7:0] d;
    strobe(8'h44); rd(4'h1, d);
    strobe(8'h55); rd(4'h1, d);
    strobe(8'h66); rd(4'h1, d);
    check("R6 extra reads", d, 8'h66);
    port_pins = 8'h99;
    rd(4'h1, d);
    check("R6 current byte", d, 8'h66);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    strobe(8'h77);
    @(negedge clk);
    port_pins = 8'h88; byte_rdy = 1'b1; reg_sel = 4'h1; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; byte_rdy = 1'b0;
    check("R10 old byte", d, 8'h77);
    check("R7 edge wins flag", {7'b0, rdy_flag}, 8'h01);
    rd(4'h1, d);
    check("R10 not captured", d, 8'h77);
    strobe(8'h9E);
    rd(4'h1, d);
    check("R10 left armed", d, 8'h9E);
  endtask

  task automatic t_level;
    logic [7:0] d;
    rd(4'h1, d);
    @(negedge clk);
    port_pins = 8'hC3; byte_rdy = 1'b1;
    @(negedge clk);
    rd(4'h1, d);
    check("R11 held strobe capture", d, 8'hC3);
    port_pins = 8'hD4;
    repeat (3) @(negedge clk);
    rd(4'h1, d);
    check("R11 level ignored", d, 8'hC3);
    byte_rdy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_misc;
    logic [7:0] d;
    latch_en = 1'b0;
    port_pins = 8'hE7;
    rd(4'h1, d);
    check("R9 live via offset 1", d, 8'hE7);
    latch_en = 1'b1;
    hs_mode = 1'b0;
    rd(4'h1, d);
    check("R8 no pulse when mode off", {7'b0, hs_n}, 8'h01);
    hs_mode = 1'b1;
    rd(4'h5, d);
    check("R12 other offset", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_vs_live();
    t_many_strobes();
    t_keep_current();
    t_same_cycle();
    t_level();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule